// File: doc/BRIEF.md
# Watchdog Timer with Reset Sequencer and Reset-Cause Latch

This block supervises a chip's reset. It has a watchdog counter in the low-speed clock domain, a merger of all reset requests, and a record of why the last resets happened. The watchdog keeps counting while the main clock is gated off in deep sleep. If software stops servicing it, it pulls the chip into reset even when no main-clock edge arrives.

There are four reset requests: a power-on input from the analog detector, an active-low external pin, a one-cycle software request and the watchdog timeout. They are combined into one raw reset. That reset asserts asynchronously and is released through a synchronizer in each clock domain. The power-on input clears only the cause latch and the handshake flops, so a recorded cause stays in place through the resets it describes. Software clears cause bits by writing ones.

Top module: `wdt_rst_ctrl`

## Requirements
- R1: After power-on (`por_n` released, clocks running) both reset outputs go high, `rst_cause` reads 0 and `wd_count` reads 0.
- R2: A low level on `ext_rst_n` drives `sys_rst_n` low at once, with no clock edge. While the main clock runs during the pulse, cause bit 0 (pin) is set.
- R3: When the last request goes away, `sys_rst_n` stays low for the next main-clock rising edge and rises on the second one. `lf_rst_n` is released the same way on low-speed edges.
- R4: A one-cycle `sw_rst_req` pulse, sampled while out of reset, drives `sys_rst_n` low by the next main-clock edge and sets cause bit 2 (software).
- R5: The watchdog counter advances on `clk_lf` while `clk_sys` is stopped. A timeout during that time asserts `sys_rst_n` with no main-clock edge and holds it low until the main clock returns. The watchdog cause is then recorded.
- R6: With `wd_en` high and no service, the count rises by one per `clk_lf` cycle. When it reaches `wd_limit`, a system reset follows and cause bit 1 (watchdog) is set.
- R7: Each `wd_kick` pulse reloads the count to 0. Kicks that arrive more often than the timeout prevent any reset.
- R8: While `wd_en` is low, `wd_count` is held at 0 and no watchdog reset occurs.
- R9: Cause bits are sticky. A pin, software or watchdog reset leaves every bit that is already set unchanged.
- R10: A `cause_clr_we` pulse clears exactly the cause bits that are one in `cause_clr_mask` and leaves the others set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Main clock; may be stopped in deep sleep |
| clk_lf | input | 1 | Free-running low-speed clock for the watchdog |
| por_n | input | 1 | Power-on reset from the analog detector, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sw_rst_req | input | 1 | Software reset request, one `clk_sys` cycle |
| wd_en | input | 1 | Watchdog enable (quasi-static level) |
| wd_limit | input | CNT_W | Timeout in `clk_lf` cycles (quasi-static) |
| wd_kick | input | 1 | Service pulse, one `clk_sys` cycle |
| cause_clr_we | input | 1 | Write strobe for clearing cause bits |
| cause_clr_mask | input | 3 | Ones select the cause bits to clear |
| sys_rst_n | output | 1 | System reset for the main-clock domain, active low |
| lf_rst_n | output | 1 | Reset for the low-speed domain, active low |
| rst_cause | output | 3 | Sticky causes: bit0 pin, bit1 watchdog, bit2 software |
| wd_count | output | CNT_W | Current watchdog count (`clk_lf` domain) |

## Verification
The watchdog is driven with four pairs of timeout and kick interval. Kicks that come well inside the timeout must leave the reset count unchanged. Sparse or missing kicks must produce exactly one watchdog reset with bit 1 recorded, which separates reload from free-running behaviour. A further run stops the main clock part way through counting and shows that the count still advances and that the reset asserts with no main-clock edge. Pin and software resets placed over existing cause bits, followed by partial mask clears, separate the sticky setting from the selective clearing.

// File: rtl/wdt_rc_pkg.sv
package wdt_rc_pkg;
   localparam int CAUSE_W    = 3;
   localparam int CAUSE_PIN  = 0;
   localparam int CAUSE_WDOG = 1;
   localparam int CAUSE_SOFT = 2;
   typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/wdt_rc_sync.sv
module wdt_rc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wdt_rc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= {STAGES{RST_VAL}};
      else         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wdt_rc_rst_sync.sv
module wdt_rc_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic raw_n,
   output logic rst_n
);
   wdt_rc_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) i_chain (
      .clk(clk), .arst_n(raw_n), .d(1'b1), .q(rst_n)
   );

   // R3: release only after the raw request was already gone at the previous edge
   assert_release_sync_R3: assert property (@(posedge clk) disable iff (!raw_n)
      $rose(rst_n) |-> $past(raw_n));
endmodule

// File: rtl/wdt_rc_core.sv
module wdt_rc_core #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_n,
   input  logic             en_async,
   input  logic [CNT_W-1:0] limit,
   input  logic             kick_tog,
   input  logic             ack_async,
   output logic [CNT_W-1:0] cnt,
   output logic             bite
);
   generate
      if (CNT_W < 4 || CNT_W > 32) begin : g_bad_width
         $error("wdt_rc_core: CNT_W must lie in 4..32");
      end
   endgenerate

   logic en_s, tog_s, tog_d, ack_s, kick_det, fire;
   logic [CNT_W-1:0] cnt_q;
   logic bite_q;

   wdt_rc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_en_sync (
      .clk(clk), .arst_n(rst_n), .d(en_async), .q(en_s));
   wdt_rc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_kick_sync (
      .clk(clk), .arst_n(rst_n), .d(kick_tog), .q(tog_s));
   wdt_rc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_ack_sync (
      .clk(clk), .arst_n(por_n), .d(ack_async), .q(ack_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_d <= 1'b0;
      else        tog_d <= tog_s;
   end

   assign kick_det = tog_s ^ tog_d;
   assign fire     = en_s && !kick_det && (cnt_q >= limit) && !ack_s && !bite_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (!en_s || kick_det) cnt_q <= '0;
      else if (cnt_q < limit)     cnt_q <= cnt_q + 1'b1;
   end

   // timeout flag lives across the reset it causes; cleared by the main-domain handshake
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     bite_q <= 1'b0;
      else if (ack_s) bite_q <= 1'b0;
      else if (fire)  bite_q <= 1'b1;
   end

   assign cnt  = cnt_q;
   assign bite = bite_q;

   assert_disabled_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> (cnt_q == '0));
   assert_kick_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_s && kick_det) |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_rc_cause.sv
module wdt_rc_cause
   import wdt_rc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic   clk,
   input  logic   por_n,
   input  logic   rst_n,
   input  logic   pin_n,
   input  logic   sw_req,
   input  logic   bite_async,
   input  logic   clr_we,
   input  cause_t clr_mask,
   output cause_t cause,
   output logic   sw_pend,
   output logic   bite_seen
);
   logic   pin_s, pend_q;
   cause_t cause_q, set_v, clr_v;

   wdt_rc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_pin_sync (
      .clk(clk), .arst_n(por_n), .d(pin_n), .q(pin_s));
   wdt_rc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_bite_sync (
      .clk(clk), .arst_n(por_n), .d(bite_async), .q(bite_seen));

   // request held until the reset it raises is seen
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      pend_q <= 1'b0;
      else if (!rst_n) pend_q <= 1'b0;
      else if (sw_req) pend_q <= 1'b1;
   end

   always_comb begin
      set_v             = '0;
      set_v[CAUSE_PIN]  = !pin_s;
      set_v[CAUSE_WDOG] = bite_seen;
      set_v[CAUSE_SOFT] = sw_req && rst_n;
      clr_v             = clr_we ? clr_mask : '0;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) cause_q <= '0;
      else        cause_q <= (cause_q & ~clr_v) | set_v;
   end

   assign cause   = cause_q;
   assign sw_pend = pend_q;

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
      (|($past(cause_q) & ~cause_q)) |-> $past(clr_we));
endmodule

// File: rtl/wdt_rst_ctrl.sv
module wdt_rst_ctrl
   import wdt_rc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk_sys,
   input  logic                 clk_lf,
   input  logic                 por_n,
   input  logic                 ext_rst_n,
   input  logic                 sw_rst_req,
   input  logic                 wd_en,
   input  logic [CNT_W-1:0]     wd_limit,
   input  logic                 wd_kick,
   input  logic                 cause_clr_we,
   input  logic [CAUSE_W-1:0]   cause_clr_mask,
   output logic                 sys_rst_n,
   output logic                 lf_rst_n,
   output logic [CAUSE_W-1:0]   rst_cause,
   output logic [CNT_W-1:0]     wd_count
);
   logic raw_n, sw_pend, bite, bite_seen, kick_tog;

   assign raw_n = por_n & ext_rst_n & ~sw_pend & ~bite;

   wdt_rc_rst_sync #(.STAGES(SYNC_STAGES)) i_sys_rst (
      .clk(clk_sys), .raw_n(raw_n), .rst_n(sys_rst_n));
   wdt_rc_rst_sync #(.STAGES(SYNC_STAGES)) i_lf_rst (
      .clk(clk_lf), .raw_n(raw_n), .rst_n(lf_rst_n));

   always_ff @(posedge clk_sys or negedge sys_rst_n) begin
      if (!sys_rst_n)   kick_tog <= 1'b0;
      else if (wd_kick) kick_tog <= ~kick_tog;
   end

   wdt_rc_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_core (
      .clk(clk_lf), .rst_n(lf_rst_n), .por_n(por_n), .en_async(wd_en),
      .limit(wd_limit), .kick_tog(kick_tog), .ack_async(bite_seen),
      .cnt(wd_count), .bite(bite));

   wdt_rc_cause #(.SYNC_STAGES(SYNC_STAGES)) i_cause (
      .clk(clk_sys), .por_n(por_n), .rst_n(sys_rst_n), .pin_n(ext_rst_n),
      .sw_req(sw_rst_req), .bite_async(bite), .clr_we(cause_clr_we),
      .clr_mask(cause_clr_mask), .cause(rst_cause), .sw_pend(sw_pend),
      .bite_seen(bite_seen));

   assert_pin_async_R2: assert property (@(posedge clk_sys) disable iff (!por_n)
      !ext_rst_n |-> !sys_rst_n);
   assert_sw_resets_R4: assert property (@(posedge clk_sys) disable iff (!por_n)
      (sw_rst_req && sys_rst_n) |=> !sys_rst_n);
   assert_bite_resets_R6: assert property (@(posedge clk_lf) disable iff (!por_n)
      bite |-> !lf_rst_n);
endmodule

// File: tb/test_wdt_rst_ctrl.sv
`timescale 1ns/1ps
module test_wdt_rst_ctrl;
   logic clk_sys = 1'b0, clk_lf = 1'b0, sys_run = 1'b1;
   logic por_n, ext_rst_n, sw_rst_req, wd_en, wd_kick, cause_clr_we;
   logic [15:0] wd_limit;
   logic [2:0]  cause_clr_mask;
   logic sys_rst_n, lf_rst_n;
   logic [2:0]  rst_cause;
   logic [15:0] wd_count;
   int total = 0, fails = 0, rst_events = 0;

   always #2.5 clk_sys = sys_run ? ~clk_sys : 1'b0;
   always #20  clk_lf  = ~clk_lf;
   always @(negedge sys_rst_n) rst_events++;

   wdt_rst_ctrl i_wdt_rst_ctrl (.*);

   // timeout in lf cycles, kick interval in sys cycles, reset expected
   localparam int V_LIMIT [4] = '{20, 20, 60, 8};
   localparam int V_GAP   [4] = '{40, 480, 200, 200};
   localparam int V_EXP   [4] = '{0, 1, 0, 1};

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_cause(logic [2:0] m);
      @(negedge clk_sys); cause_clr_we = 1'b1; cause_clr_mask = m;
      @(negedge clk_sys); cause_clr_we = 1'b0; cause_clr_mask = '0;
   endtask

   task automatic pin_reset();
      @(negedge clk_sys); ext_rst_n = 1'b0;
      repeat (6) @(negedge clk_sys);
      ext_rst_n = 1'b1;
      repeat (6) @(negedge clk_sys);
   endtask

   initial begin
      #2000000;
      fails++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int ev0, c1, c2;
      por_n = 1'b0; ext_rst_n = 1'b1; sw_rst_req = 1'b0; wd_en = 1'b0;
      wd_kick = 1'b0; cause_clr_we = 1'b0; cause_clr_mask = '0; wd_limit = 16'd100;
      repeat (10) @(negedge clk_sys);
      por_n = 1'b1;
      repeat (30) @(negedge clk_sys);
      chk("R1 sys_rst_n", sys_rst_n, 1);
      chk("R1 lf_rst_n", lf_rst_n, 1);
      chk("R1 cause", rst_cause, 0);
      chk("R1 count", wd_count, 0);

      // R2 asynchronous assertion, R3 two-edge release
      @(negedge clk_sys); ext_rst_n = 1'b0;
      #1 chk("R2 async assert", sys_rst_n, 0);
      repeat (5) @(negedge clk_sys);
      ext_rst_n = 1'b1;
      @(negedge clk_sys); chk("R3 low after first edge", sys_rst_n, 0);
      @(negedge clk_sys); chk("R3 high after second edge", sys_rst_n, 1);
      repeat (20) @(negedge clk_sys);
      chk("R2 pin cause", rst_cause, 3'b001);

      // R4 software reset, R9 pin bit kept
      @(negedge clk_sys); sw_rst_req = 1'b1;
      @(negedge clk_sys); sw_rst_req = 1'b0;
      chk("R4 sw asserts", sys_rst_n, 0);
      repeat (20) @(negedge clk_sys);
      chk("R4 released", sys_rst_n, 1);
      chk("R9 pin+sw cause", rst_cause, 3'b101);

      // R10 selective clear
      clear_cause(3'b001);
      chk("R10 clear pin only", rst_cause, 3'b100);
      clear_cause(3'b100);
      chk("R10 clear sw", rst_cause, 3'b000);

      // R8 disabled watchdog
      ev0 = rst_events; wd_limit = 16'd5; wd_en = 1'b0;
      repeat (40) @(negedge clk_lf);
      chk("R8 count held", wd_count, 0);
      chk("R8 no reset", rst_events - ev0, 0);

      // R6 counting
      @(negedge clk_sys); wd_limit = 16'd1000; wd_en = 1'b1;
      repeat (20) @(negedge clk_lf);
      chk("R6 counting", int'(wd_count >= 12 && wd_count <= 20), 1);
      @(negedge clk_sys); wd_en = 1'b0;
      repeat (5) @(negedge clk_lf);
      chk("R8 back to zero", wd_count, 0);

      // vector table: R6 timeout and R7 service
      for (int v = 0; v < 4; v++) begin
         string req;
         req = (V_EXP[v] != 0) ? "R6" : "R7";
         clear_cause(3'b111);
         ev0 = rst_events;
         wd_limit = 16'(V_LIMIT[v]); wd_en = 1'b1;
         for (int i = 0; i < 1600; i++) begin
            @(negedge clk_sys);
            wd_kick = ((i % V_GAP[v]) == V_GAP[v] - 1);
            if (rst_events != ev0) begin
               wd_en = 1'b0; wd_kick = 1'b0;
               break;
            end
         end
         @(negedge clk_sys); wd_kick = 1'b0; wd_en = 1'b0;
         repeat (120) @(negedge clk_sys);
         chk({req, " reset seen"}, int'(rst_events != ev0), V_EXP[v]);
         chk({req, " wdog cause"}, rst_cause[1], V_EXP[v]);
         chk({req, " released"}, sys_rst_n, 1);
      end

      // R5 counting and timeout with main clock stopped
      clear_cause(3'b111);
      @(negedge clk_sys); wd_limit = 16'd40; wd_en = 1'b1;
      repeat (10) @(negedge clk_lf);
      @(negedge clk_sys); sys_run = 1'b0;
      @(negedge clk_lf); c1 = wd_count;
      repeat (5) @(negedge clk_lf); c2 = wd_count;
      chk("R5 count advances", int'(c2 > c1), 1);
      repeat (60) @(negedge clk_lf);
      chk("R5 reset while stopped", sys_rst_n, 0);
      wd_en = 1'b0;
      sys_run = 1'b1;
      repeat (150) @(negedge clk_sys);
      chk("R5 released", sys_rst_n, 1);
      chk("R5 wdog cause", rst_cause, 3'b010);

      // R9 sticky watchdog bit across a pin reset
      pin_reset();
      repeat (20) @(negedge clk_sys);
      chk("R9 wdog+pin", rst_cause, 3'b011);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule